// File: doc/BRIEF.md
# Over-Current Fault Latch Controller

This block holds the digital fault logic of a phase current sensor. An analog comparator outside the block raises a flag whenever the magnitude of the differential sense voltage goes past the trip threshold, for either polarity. The block requires that flag to stay up for a debounce interval before it acts. It then latches a fault, pulls its active-low open-drain fault pin and releases the open-drain PWM output driver, so an external resistor pulls the PWM line high.

A latched fault clears only through the shared PWM pin. The block senses the level of that pin and measures how long an external agent holds it low while the block's own driver is released. Once the low time reaches the reset interval, the latch opens, the fault pin is released and the PWM driver is enabled again. If the over-current condition has not gone away, the fault returns at the next SYNC transition without a second debounce. If the fault pin is wired straight to the PWM pin, the asserted fault pulls the PWM line low itself, and this satisfies the reset condition. The result is periodic automatic clearing and re-checking.

All asynchronous inputs pass through a multi-flop synchronizer. Both time intervals are counted in system clock cycles and are set by parameters.

Top module: `ocf_latch_ctrl`

## Requirements
- R1: After reset, `fault_n_o` is 1 (released) and `pwm_en_o` is 1 (PWM driver enabled).
- R2: When the synchronized over-current flag is high for DEBOUNCE_CYC consecutive clock samples while the block is idle, the fault latches: `fault_n_o` goes to 0 and `pwm_en_o` goes to 0.
- R3: A high run on the over-current flag shorter than DEBOUNCE_CYC samples does not latch. Any single low sample restarts the debounce count from zero, so separate short runs never add up.
- R4: Once latched, the fault stays asserted with the PWM driver released, whatever the over-current flag does afterwards.
- R5: While the fault is latched, a synchronized PWM pin level of 0 for RESET_CYC consecutive samples clears the latch: `fault_n_o` returns to 1 and `pwm_en_o` returns to 1.
- R6: A low run on the PWM pin shorter than RESET_CYC samples leaves the fault latched. A high sample restarts the reset count.
- R7: A low level on the PWM pin while no fault is latched changes no output, and it adds nothing toward a later reset interval.
- R8: After the latch clears, both outputs stay released and enabled until the next SYNC transition. At that transition, an over-current flag that is still high re-latches the fault at once, with no debounce. A low flag returns the block to idle, and any later fault needs the full debounce again.
- R9: With SYNC_EDGE_MODE = 1, both rising and falling SYNC transitions count as the re-arm event. With SYNC_EDGE_MODE = 0, only rising transitions count.
- R10: With `fault_n_o` wired onto the PWM pin and the over-current flag held high, the fault clears and re-latches repeatedly, once per reset interval plus wait for a SYNC transition. When the flag drops, the block settles released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_flag_i | input | 1 | Comparator over-current flag (asynchronous, active high) |
| sync_i | input | 1 | SYNC carrier clock (asynchronous) |
| pwm_pin_i | input | 1 | Sensed level of the shared open-drain PWM line |
| fault_n_o | output | 1 | Fault pin, active low, 0 = pull the line low |
| pwm_en_o | output | 1 | 1 = PWM driver may pull its pin, 0 = driver released |

## Verification
The bench builds the block with DEBOUNCE_CYC = 6, RESET_CYC = 5, two synchronizer stages and SYNC_EDGE_MODE = 1. These short intervals make it possible to sweep every over-current pulse length and every PWM-low length from one sample to past the threshold, and to compare each outcome with the length-versus-threshold rule. The same configuration keeps the re-arm on both SYNC edge directions and the wired auto-reset loop to a few hundred cycles. A wired-AND model of the PWM line in the bench lets the fault pin drive the line for the auto-reset case.

// File: rtl/ocf_pkg.sv
package ocf_pkg;

   typedef enum logic [1:0] {
      OCF_IDLE    = 2'd0,
      OCF_FAULT   = 2'd1,
      OCF_CLEARED = 2'd2
   } ocf_state_t;

   localparam int OCF_EDGE_RISE = 0;
   localparam int OCF_EDGE_BOTH = 1;

endpackage

// File: rtl/ocf_sync.sv
// Multi-flop synchronizer for one asynchronous level.
module ocf_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ocf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ocf_edge.sv
// Transition detector on a synchronized level; the variant is picked by parameter.
module ocf_edge #(
   parameter int EDGE_MODE = ocf_pkg::OCF_EDGE_BOTH
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic evt_o
);

   generate
      if (EDGE_MODE != ocf_pkg::OCF_EDGE_RISE && EDGE_MODE != ocf_pkg::OCF_EDGE_BOTH) begin : g_bad_mode
         $error("ocf_edge: unsupported EDGE_MODE");
      end
   endgenerate

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
      end else begin
         prev_q <= lvl_i;
      end
   end

   generate
      if (EDGE_MODE == ocf_pkg::OCF_EDGE_RISE) begin : g_rise
         assign evt_o = lvl_i & ~prev_q;
      end else begin : g_both
         assign evt_o = lvl_i ^ prev_q;
      end
   endgenerate

   AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> (lvl_i != prev_q)); // R9

endmodule

// File: rtl/ocf_hold.sv
// Persistence timer: trip fires on the HOLD_CYC-th consecutive sample with
// en_i and cond_i both high; any gap restarts the count.
module ocf_hold #(
   parameter int HOLD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic cond_i,
   output logic trip_o
);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("ocf_hold: HOLD_CYC must be at least 1");
      end
   endgenerate

   localparam int            CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             active;

   assign active = en_i & cond_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign trip_o = active & (cnt_q == LAST);

   AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R3
   AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/ocf_latch_ctrl.sv
// Over-current fault latch with debounce, pin-sensed release and SYNC re-arm.
module ocf_latch_ctrl #(
   parameter int SYNC_STAGES    = 2,
   parameter int DEBOUNCE_CYC   = 350,
   parameter int RESET_CYC      = 200,
   parameter int SYNC_EDGE_MODE = ocf_pkg::OCF_EDGE_BOTH
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oc_flag_i,
   input  logic sync_i,
   input  logic pwm_pin_i,
   output logic fault_n_o,
   output logic pwm_en_o
);

   import ocf_pkg::*;

   ocf_state_t state_q, state_d;
   logic oc_s, sync_s, pin_s;
   logic sync_evt, deb_trip, rel_trip;

   ocf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_oc (
      .clk(clk), .rst_n(rst_n), .d_i(oc_flag_i), .q_o(oc_s));
   ocf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d_i(sync_i), .q_o(sync_s));
   ocf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_pin (
      .clk(clk), .rst_n(rst_n), .d_i(pwm_pin_i), .q_o(pin_s));

   ocf_edge #(.EDGE_MODE(SYNC_EDGE_MODE)) u_sync_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(sync_s), .evt_o(sync_evt));

   // Debounce only counts while idle.
   ocf_hold #(.HOLD_CYC(DEBOUNCE_CYC)) u_debounce (
      .clk(clk), .rst_n(rst_n), .en_i(state_q == OCF_IDLE),
      .cond_i(oc_s), .trip_o(deb_trip));

   // Release timer counts only while latched, when the own driver is off.
   ocf_hold #(.HOLD_CYC(RESET_CYC)) u_release (
      .clk(clk), .rst_n(rst_n), .en_i(state_q == OCF_FAULT),
      .cond_i(~pin_s), .trip_o(rel_trip));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         OCF_IDLE:    if (deb_trip) state_d = OCF_FAULT;
         OCF_FAULT:   if (rel_trip) state_d = OCF_CLEARED;
         OCF_CLEARED: if (sync_evt) state_d = oc_s ? OCF_FAULT : OCF_IDLE;
         default:     state_d = OCF_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= OCF_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign fault_n_o = (state_q != OCF_FAULT);
   assign pwm_en_o  = (state_q != OCF_FAULT);

   AST_LATCH_NEEDS_OC: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == OCF_IDLE && state_d == OCF_FAULT) |-> oc_s); // R2
   AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == OCF_FAULT && pin_s) |=> (state_q == OCF_FAULT)); // R4
   AST_CLEAR_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == OCF_FAULT) |=> (state_q == OCF_FAULT) || (state_q == OCF_CLEARED && !$past(pin_s))); // R5
   AST_REARM_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == OCF_CLEARED && !sync_evt) |=> (state_q == OCF_CLEARED)); // R8
   AST_IDLE_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == OCF_IDLE && !oc_s) |=> (state_q == OCF_IDLE)); // R7

endmodule

// File: tb/ocf_latch_ctrl_bench.sv
module ocf_latch_ctrl_bench;

   localparam int DEB = 6;
   localparam int RST = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic oc = 1'b0;
   logic sync = 1'b0;
   logic ext_low = 1'b0;
   logic tie = 1'b0;
   logic fault_n, pwm_en, pin;
   int   errors = 0;
   int   checks = 0;

   always #4 clk = ~clk;

   // Wired-AND model of the open-drain PWM line (block's own pulses idle).
   assign pin = ~ext_low & ~(tie & ~fault_n);

   ocf_latch_ctrl #(
      .SYNC_STAGES(2), .DEBOUNCE_CYC(DEB), .RESET_CYC(RST), .SYNC_EDGE_MODE(1)
   ) u_ocf_latch_ctrl (
      .clk(clk), .rst_n(rst_n), .oc_flag_i(oc), .sync_i(sync),
      .pwm_pin_i(pin), .fault_n_o(fault_n), .pwm_en_o(pwm_en));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic toggle_sync();
      sync = ~sync;
      tick(5);
   endtask

   // Bring a latched block back to idle with the flag low.
   task automatic recover();
      oc = 1'b0;
      ext_low = 1'b1; tick(RST + 4); ext_low = 1'b0; tick(4);
      toggle_sync();
   endtask

   task automatic latch_fault();
      oc = 1'b1; tick(DEB + 4);
   endtask

   initial begin
      tick(3);
      chk("R1 fault_n", fault_n, 1);
      chk("R1 pwm_en", pwm_en, 1);
      rst_n = 1'b1;
      tick(3);
      chk("R1 fault_n after release", fault_n, 1);

      // R2/R3: sweep over-current pulse lengths
      for (int len = 1; len <= DEB + 2; len++) begin
         oc = 1'b1; tick(len); oc = 1'b0; tick(8);
         chk(len >= DEB ? "R2 latch on long pulse" : "R3 short pulse ignored",
             fault_n, (len >= DEB) ? 0 : 1);
         if (len >= DEB) begin
            chk("R2 pwm released", pwm_en, 0);
            chk("R4 stays latched with flag low", fault_n, 0);
            recover();
         end
      end

      // R3: interrupted runs never add up
      oc = 1'b1; tick(DEB - 1); oc = 1'b0; tick(1);
      oc = 1'b1; tick(DEB - 1); oc = 1'b0; tick(8);
      chk("R3 dropout restarts debounce", fault_n, 1);

      // R7: pin low while idle
      ext_low = 1'b1; tick(40);
      chk("R7 idle pin low fault_n", fault_n, 1);
      chk("R7 idle pin low pwm_en", pwm_en, 1);
      ext_low = 1'b0; tick(4);
      latch_fault();
      chk("R2 latch", fault_n, 0);
      ext_low = 1'b1; tick(RST - 1); ext_low = 1'b0; tick(8);
      chk("R7 idle lows not counted", fault_n, 0);
      recover();
      chk("R5 recovered", fault_n, 1);

      // R5/R6: sweep pin-low lengths
      for (int len = 1; len <= RST + 2; len++) begin
         latch_fault(); oc = 1'b0;
         ext_low = 1'b1; tick(len); ext_low = 1'b0; tick(8);
         chk(len >= RST ? "R5 clear on long low" : "R6 short low ignored",
             fault_n, (len >= RST) ? 1 : 0);
         if (len >= RST) begin
            chk("R5 pwm re-enabled", pwm_en, 1);
            toggle_sync();
         end else begin
            recover();
         end
      end

      // R6: interrupted low runs
      latch_fault(); oc = 1'b0;
      ext_low = 1'b1; tick(RST - 1); ext_low = 1'b0; tick(1);
      ext_low = 1'b1; tick(RST - 1); ext_low = 1'b0; tick(8);
      chk("R6 gap restarts reset count", fault_n, 0);
      recover();

      // R8: re-arm at next SYNC edge while flag persists
      latch_fault();
      ext_low = 1'b1; tick(RST + 3); ext_low = 1'b0; tick(30);
      chk("R8 released until SYNC edge", fault_n, 1);
      sync = ~sync; tick(1);
      chk("R8 not yet re-latched", fault_n, 1);
      tick(3);
      chk("R8 re-latched at SYNC edge", fault_n, 0);
      chk("R8 pwm released on re-latch", pwm_en, 0);
      ext_low = 1'b1; tick(RST + 3); ext_low = 1'b0; tick(10);
      chk("R5 clear again", fault_n, 1);
      sync = ~sync; tick(4);
      chk("R9 opposite SYNC edge re-arms", fault_n, 0);
      ext_low = 1'b1; tick(RST + 3); ext_low = 1'b0; tick(10);
      oc = 1'b0; tick(4);
      toggle_sync();
      chk("R8 back to idle with flag low", fault_n, 1);
      oc = 1'b1; tick(DEB - 1); oc = 1'b0; tick(8);
      chk("R8 fresh debounce required", fault_n, 1);

      // R10: auto-reset with fault pin tied to PWM pin
      begin
         int falls = 0;
         int rises = 0;
         logic prev;
         tie = 1'b1; oc = 1'b1;
         prev = fault_n;
         for (int i = 0; i < 300; i++) begin
            if (i % 20 == 10) sync = ~sync;
            tick(1);
            if (prev && !fault_n) falls++;
            if (!prev && fault_n) rises++;
            prev = fault_n;
         end
         chk("R10 repeated latching", (falls >= 2) ? 1 : 0, 1);
         chk("R10 repeated clearing", (rises >= 1) ? 1 : 0, 1);
         oc = 1'b0;
         for (int i = 0; i < 100; i++) begin
            if (i % 20 == 10) sync = ~sync;
            tick(1);
         end
         chk("R10 settles released", fault_n, 1);
         chk("R10 pwm enabled", pwm_en, 1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule